// File: doc/BRIEF.md
# Shared and Private Interrupt Mask Controller

This block gathers interrupt requests for one processor and decides which of them reach it. It receives 64 level-sensitive shared request lines, split into a low bank (lines 0-31) and a high bank (lines 32-63). It also receives 8 lines that are private to the processor, numbered 64 upward in the global scheme. Each line has an enable bit. Software changes enables only through a pair of strobe registers per bank: one register sets bits, the other clears them. The processor sees every enabled pending line through a single registered IRQ output.

The controller never clears a request. A line stays pending for as long as its source device holds it high, so the handler must silence the device itself. A summary register collects the enabled private lines and one flag per shared bank. It also carries copies of eleven commonly used shared lines, so a handler can often find its source with a single read. Those copies are enabled only through the shared-bank registers.

All registers are 32 bits wide and sit at byte offsets 0x200 to 0x224. Access uses a simple bus with a write strobe, an address, write data and combinational read data.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset all enables are 0, irq_o is 0, and every mapped register reads 0 while all request lines are low.
- R2: A write to 0x210 (lines 0-31), 0x214 (lines 32-63) or 0x218 (private lines, bits 7:0) sets each enable whose data bit is 1. Enables whose data bit is 0 keep their value.
- R3: A write to 0x21C (lines 0-31), 0x220 (lines 32-63) or 0x224 (private lines, bits 7:0) clears each enable whose data bit is 1. Enables whose data bit is 0 keep their value.
- R4: Reading either the set register or the clear register of a bank returns that bank's current enable mask. Private enables appear in bits 7:0 and the upper bits read 0.
- R5: 0x204 reads line i AND enable i for lines 0-31. 0x208 reads the same for lines 32-63, with line 32+j in bit j.
- R6: In the summary register at 0x200, bits 7:0 are the private lines ANDed with their enables. Bit 8 is 1 when any enabled line 0-31 is high. Bit 9 is 1 when any enabled line 32-63 is high.
- R7: Summary bits 10 to 20 show, in this order, enabled shared lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62. Summary bits 31:21 read 0.
- R8: Writes to 0x218 or 0x224 ignore data bits 31:8 and never change any shared enable, including the enables of the lines copied into the summary.
- R9: There is no pending-clear. An enabled line that is held high stays pending, and writes to 0x200, 0x204 and 0x208 change neither enables nor pending state.
- R10: irq_o is the registered OR of all enabled pending lines across all three banks. It follows a change on a line or an enable one clock later.
- R11: 0x20C holds the last word written to it, reads it back, and has no effect on irq_o. Reads from any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_irq_i | input | 64 | Shared level request lines 0-63 |
| private_irq_i | input | 8 | Processor-private level request lines |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
Enable masks are built by sparse set writes and then punched by clear writes. This shows the difference between true set/clear behaviour and plain overwrite, and shows that zero bits are kept.

All request lines are then driven high against a partly enabled mask. The pending views must then show exactly the mask, which tells masking apart from a raw pass-through. The summary is tried with every copied line enabled and then with one of them disabled. This finds a copy that is wired to the wrong bit. Basic-bank writes with upper bits set must not touch it.

The IRQ output is sampled one cycle before and one cycle after each line or enable change. This separates a registered output from a combinational one. It also separates a held level from a pulse that clears itself.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int ADDR_W = 12,
  parameter int NPRIV  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       shared_irq_i,
  input  logic [NPRIV-1:0]  private_irq_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] A_PND0 = ADDR_W'('h204);
  localparam logic [ADDR_W-1:0] A_PND1 = ADDR_W'('h208);
  localparam logic [ADDR_W-1:0] A_FIQ  = ADDR_W'('h20C);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'('h210);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'('h214);
  localparam logic [ADDR_W-1:0] A_SETP = ADDR_W'('h218);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'('h21C);
  localparam logic [ADDR_W-1:0] A_CLR1 = ADDR_W'('h220);
  localparam logic [ADDR_W-1:0] A_CLRP = ADDR_W'('h224);
  localparam int NMIR = 11;
  localparam int MIR_LINE [NMIR] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

  logic [63:0]      en_sh;
  logic [NPRIV-1:0] en_pv;
  logic [31:0]      fiq_q;
  logic             irq_q;

  wire [63:0]      pend_sh = shared_irq_i & en_sh;
  wire [NPRIV-1:0] pend_pv = private_irq_i & en_pv;
  wire             any_pend = (|pend_sh) | (|pend_pv);

  logic [NMIR-1:0] mir;
  for (genvar k = 0; k < NMIR; k++) begin : g_mir
    assign mir[k] = pend_sh[MIR_LINE[k]];
  end

  wire [31:0] summary = {{(32-10-NMIR){1'b0}}, mir, |pend_sh[63:32], |pend_sh[31:0],
                         {(8-NPRIV){1'b0}}, pend_pv};
  wire [31:0] en_pv_w = {{(32-NPRIV){1'b0}}, en_pv};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_sh <= '0;
      en_pv <= '0;
      fiq_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= any_pend;
      if (bus_wr_i) begin
        unique case (bus_addr_i)
          A_SET0:  en_sh[31:0]  <= en_sh[31:0]  |  bus_wdata_i;
          A_SET1:  en_sh[63:32] <= en_sh[63:32] |  bus_wdata_i;
          A_SETP:  en_pv        <= en_pv        |  bus_wdata_i[NPRIV-1:0];
          A_CLR0:  en_sh[31:0]  <= en_sh[31:0]  & ~bus_wdata_i;
          A_CLR1:  en_sh[63:32] <= en_sh[63:32] & ~bus_wdata_i;
          A_CLRP:  en_pv        <= en_pv        & ~bus_wdata_i[NPRIV-1:0];
          A_FIQ:   fiq_q        <= bus_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      A_SUM:         bus_rdata_o = summary;
      A_PND0:        bus_rdata_o = pend_sh[31:0];
      A_PND1:        bus_rdata_o = pend_sh[63:32];
      A_FIQ:         bus_rdata_o = fiq_q;
      A_SET0, A_CLR0: bus_rdata_o = en_sh[31:0];
      A_SET1, A_CLR1: bus_rdata_o = en_sh[63:32];
      A_SETP, A_CLRP: bus_rdata_o = en_pv_w;
      default:       bus_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == A_SET0) |=> ((en_sh[31:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == A_CLR1) |=> ((en_sh[63:32] & $past(bus_wdata_i)) == 32'h0));

  p_basic_keeps_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && (bus_addr_i == A_SETP || bus_addr_i == A_CLRP)) |=> $stable(en_sh));

  p_pend_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && (bus_addr_i == A_SUM || bus_addr_i == A_PND0 || bus_addr_i == A_PND1))
      |=> ($stable(en_sh) && $stable(en_pv)));

  p_irq_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past((|(shared_irq_i & en_sh)) | (|(private_irq_i & en_pv)))));

  p_fiq_no_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == A_FIQ) |=> ($stable(en_sh) && $stable(en_pv)));
endmodule

// File: tb/sim_irq_mask_ctrl.sv
`timescale 1ns/1ps
module sim_irq_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sh = '0;
  logic [7:0]  pv = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_mask_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .shared_irq_i(sh), .private_irq_i(pv),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic t_reset;
    for (int a = 'h200; a <= 'h224; a += 4) read_chk("R1 reset read", 12'(a), 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable;
    bus_write('h210, 32'h0000_00F0);
    read_chk("R2 set low bank", 'h210, 32'h0000_00F0);
    bus_write('h210, 32'h0000_0300);
    read_chk("R2 set keeps zeros", 'h210, 32'h0000_03F0);
    bus_write('h214, 32'h8000_0001);
    read_chk("R2 set high bank", 'h214, 32'h8000_0001);
    bus_write('h218, 32'hFFFF_FF05);
    read_chk("R8 basic set upper ignored", 'h218, 32'h0000_0005);
    read_chk("R8 low bank untouched", 'h210, 32'h0000_03F0);
    read_chk("R8 high bank untouched", 'h214, 32'h8000_0001);
  endtask

  task automatic t_disable;
    bus_write('h21C, 32'h0000_01F0);
    read_chk("R3 clear low bank", 'h210, 32'h0000_0200);
    read_chk("R4 clear reg reads mask", 'h21C, 32'h0000_0200);
    bus_write('h220, 32'h0000_0001);
    read_chk("R3 clear high bank", 'h214, 32'h8000_0000);
    read_chk("R4 clear high reads mask", 'h220, 32'h8000_0000);
    bus_write('h224, 32'hFFFF_FF01);
    read_chk("R3 clear private", 'h224, 32'h0000_0004);
    read_chk("R8 basic clear keeps shared", 'h210, 32'h0000_0200);
  endtask

  task automatic t_pending;
    sh = '1; pv = 8'hFF;
    read_chk("R5 pending low bank masked", 'h204, 32'h0000_0200);
    read_chk("R5 pending high bank masked", 'h208, 32'h8000_0000);
    read_chk("R6 summary all lines high", 'h200, 32'h0000_0B04);
    sh = 64'h0000_0000_0000_0020; pv = 8'h00;
    read_chk("R6 summary only masked line", 'h200, 32'h0000_0000);
    read_chk("R5 masked line not pending", 'h204, 32'h0);
  endtask

  task automatic t_mirror;
    bus_write('h210, 32'h000C_0480);
    bus_write('h214, 32'h43E0_0000);
    sh = 64'h43E0_0000_000C_0680; pv = 8'h00;
    read_chk("R7 all copies set", 'h200, 32'h001F_FF00);
    bus_write('h220, 32'h0080_0000);
    read_chk("R7 line 55 copy cleared", 'h200, 32'h001D_FF00);
    bus_write('h224, 32'hFFFF_FF00);
    read_chk("R8 basic clear leaves copies", 'h200, 32'h001D_FF00);
    bus_write('h218, 32'h0080_0000);
    read_chk("R8 basic set cannot enable copy", 'h200, 32'h001D_FF00);
  endtask

  task automatic t_irq;
    bus_write('h21C, '1); bus_write('h220, '1); bus_write('h224, '1);
    sh = '1; pv = 8'hFF;
    @(negedge clk);
    check("R10 all masked irq low", {31'b0, irq}, 32'h0);
    bus_write('h218, 32'h0000_0008);
    check("R10 irq not yet after enable", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R10 irq one clock after enable", {31'b0, irq}, 32'h1);
    bus_write('h200, '1); bus_write('h204, '1); bus_write('h208, '1);
    read_chk("R9 still pending after pend writes", 'h200, 32'h0000_0008);
    read_chk("R9 enables unchanged", 'h218, 32'h0000_0008);
    read_chk("R9 shared enables unchanged", 'h210, 32'h0);
    check("R9 irq held while line high", {31'b0, irq}, 32'h1);
    pv = 8'hF7;
    #1;
    check("R10 irq still high same cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R10 irq low one clock after drop", {31'b0, irq}, 32'h0);
    bus_write('h214, 32'h0000_0004);
    @(negedge clk);
    check("R10 high bank line raises irq", {31'b0, irq}, 32'h1);
    bus_write('h220, 32'h0000_0004);
    @(negedge clk);
    check("R10 irq low after disable", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_fiq;
    bus_write('h20C, 32'hDEAD_BEEF);
    read_chk("R11 fiq store readback", 'h20C, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R11 fiq no irq effect", {31'b0, irq}, 32'h0);
    read_chk("R11 unmapped 0x228", 'h228, 32'h0);
    read_chk("R11 unmapped 0x000", 'h000, 32'h0);
    read_chk("R11 unmapped 0x1FC", 'h1FC, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_enable;
    t_disable;
    t_pending;
    t_mirror;
    t_irq;
    t_fiq;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule